// File: doc/BRIEF.md
# Dual Target-Time Alarm with Pulse-Per-Second Channel

This block watches a 64-bit system time value that is supplied from outside. It compares that value against two programmable 64-bit targets. When the time reaches or passes an armed target, a sticky status bit is set. An enable mask routes the status bits onto a single interrupt line for the host. Firmware can use either channel as a one-shot scheduling alarm.

Channel 1 has an extra periodic mode. In this mode every match drives the `pps_out` pin high for a programmable number of clock cycles. The target then moves forward by one second (1,000,000,000 time units) and the channel stays armed, so it produces one pulse per second with no further writes.

Software programs the block through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `tgt_time_alarm`

## Requirements
- R1: Writing the low word of a target (address 0 for channel 0, address 2 for channel 1) only stages it. The 64-bit target {wdata, staged low} is committed when the high word is written (address 1 or 3). Reads of addresses 0..3 return the committed target.
- R2: Each channel compares the full 64-bit unsigned system time against its target using "greater than or equal". A match on an armed, enabled channel sets status bit 0 (channel 0) or bit 1 (channel 1) of address 5, and the bit is visible after the next clock edge. A time that jumps past the target also matches.
- R3: In alarm mode a channel fires once per arming. It is re-armed by committing a target while its enable bit is set, or by writing the control register (address 4) with its enable bit set.
- R4: A channel whose enable bit is clear never sets its status bit. The enable bits are bit 0 and bit 1 of address 4.
- R5: Status bits are sticky. Writing 1 to a bit of address 5 clears that bit, and writing 0 leaves it unchanged.
- R6: `irq` is high exactly when some status bit is set whose mask bit (address 6, bits 1:0) is also set.
- R7: With periodic mode on (address 4 bit 2), a channel-1 match drives `pps_out` high for the number of cycles held in address 7, starting the cycle after the match.
- R8: In periodic mode each channel-1 match adds 1,000,000,000 to the channel-1 target, and the channel stays armed.
- R9: `pps_out` stays low when periodic mode is off, including on channel-1 alarm matches and on all channel-0 matches.
- R10: After reset, all targets, enables, mask, status and pulse width are zero, and `irq` and `pps_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Free-running system time |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| pps_out | output | 1 | Periodic pulse output |

## Verification
The checker tests several rules on every cycle:
- a qualifying match always sets status on the next edge;
- an alarm match disarms its channel;
- a status bit can rise only if its channel was enabled;
- status bits persist until a write of 1 clears them;
- `irq` never rises without a status bit set;
- a periodic match advances the target by exactly one second;
- the pulse pin stays low while periodic mode is off.

Only the bench scenarios can show the rest. These are the staging of the low target word, the re-arm paths, the crossing of a 32-bit boundary, and the W1C data semantics. They also include the exact pulse widths, which a scoreboard measures for each expected pulse, and the absence of unexpected pulses.

// File: rtl/tgt_time_alarm.sv
module tgt_time_alarm #(
  parameter int          AW       = 3,
  parameter int          DW       = 32,
  parameter int          TW       = 64,
  parameter int          PW_W     = 16,
  parameter logic [63:0] PPS_STEP = 64'd1000000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          pps_out
);
  localparam int HW = TW - DW;

  logic [TW-1:0]   tgt0, tgt1;
  logic [DW-1:0]   stage0, stage1;
  logic [1:0]      en, armed, status, mask;
  logic            mode;
  logic [PW_W-1:0] width, cnt;
  logic [7:0]      wr;
  logic            hit0, hit1;

  always_comb begin
    wr = '0;
    if (reg_we) wr[reg_addr] = 1'b1;
  end

  assign hit0    = armed[0] & en[0] & (sys_time >= tgt0);
  assign hit1    = armed[1] & en[1] & (sys_time >= tgt1);
  assign irq     = |(status & mask);
  assign pps_out = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt0   <= '0;
      tgt1   <= '0;
      stage0 <= '0;
      stage1 <= '0;
      en     <= '0;
      armed  <= '0;
      status <= '0;
      mask   <= '0;
      mode   <= 1'b0;
      width  <= '0;
      cnt    <= '0;
    end else begin
      if (wr[0]) stage0 <= reg_wdata;
      if (wr[1]) tgt0 <= {reg_wdata[HW-1:0], stage0};
      if (wr[2]) stage1 <= reg_wdata;
      if (wr[3])             tgt1 <= {reg_wdata[HW-1:0], stage1};
      else if (hit1 && mode) tgt1 <= tgt1 + PPS_STEP;

      if (wr[4]) begin
        en   <= reg_wdata[1:0];
        mode <= reg_wdata[2];
      end
      if (wr[6]) mask  <= reg_wdata[1:0];
      if (wr[7]) width <= reg_wdata[PW_W-1:0];

      if (wr[4])      armed[0] <= reg_wdata[0];
      else if (wr[1]) armed[0] <= en[0];
      else if (hit0)  armed[0] <= 1'b0;

      if (wr[4])              armed[1] <= reg_wdata[1];
      else if (wr[3])         armed[1] <= en[1];
      else if (hit1 && !mode) armed[1] <= 1'b0;

      status <= (status & ~(wr[5] ? reg_wdata[1:0] : 2'b00)) | {hit1, hit0};

      if (!mode)          cnt <= '0;
      else if (hit1)      cnt <= width;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = tgt0[DW-1:0];
      3'd1:    reg_rdata = DW'(tgt0[TW-1:DW]);
      3'd2:    reg_rdata = tgt1[DW-1:0];
      3'd3:    reg_rdata = DW'(tgt1[TW-1:DW]);
      3'd4:    reg_rdata = DW'({mode, en});
      3'd5:    reg_rdata = DW'(status);
      3'd6:    reg_rdata = DW'(mask);
      default: reg_rdata = DW'(width);
    endcase
  end
endmodule

// File: rtl/tgt_time_alarm_chk.sv
module tgt_time_alarm_chk #(
  parameter logic [63:0] PPS_STEP = 64'd1000000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] sys_time,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        pps_out,
  input logic [1:0]  en,
  input logic [1:0]  armed,
  input logic [1:0]  status,
  input logic        mode,
  input logic [63:0] tgt0,
  input logic [63:0] tgt1
);
  assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[0] && en[0] && sys_time >= tgt0) |=> status[0]);

  assert_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[0] && en[0] && sys_time >= tgt0 && !reg_we) |=> !armed[0]);

  assert_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(en[0]));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(reg_we && reg_addr == 3'd5 && reg_wdata[1])) |=> status[1]);

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 2'b00));

  assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[1] && en[1] && mode && sys_time >= tgt1 && !(reg_we && reg_addr == 3'd3))
      |=> (tgt1 == $past(tgt1) + PPS_STEP));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && $past(!mode)) |-> !pps_out);
endmodule

bind tgt_time_alarm tgt_time_alarm_chk #(.PPS_STEP(PPS_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .pps_out(pps_out),
  .en(en), .armed(armed), .status(status), .mode(mode),
  .tgt0(tgt0), .tgt1(tgt1)
);

// File: tb/tgt_time_alarm_bench.sv
module tgt_time_alarm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, pps_out;

  int vectors = 0;
  int errors  = 0;
  int exp_w[$];

  always #5 clk = ~clk;

  tgt_time_alarm u_tgt_time_alarm (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pps_out(pps_out)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input logic [63:0] t);
    sys_time = t;
    @(negedge clk);
  endtask

  task automatic expect_pulse(input int w);
    exp_w.push_back(w);
  endtask

  logic pps_q = 1'b0;
  int   hi_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pps_out) hi_len++;
      if (pps_out && !pps_q && exp_w.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R7/R9: unexpected pulse, got 1 expected 0");
      end
      if (!pps_out && pps_q && exp_w.size() != 0) begin
        chk("R7 pulse width", hi_len, exp_w.pop_front());
      end
      if (!pps_out) hi_len = 0;
      pps_q = pps_out;
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R10 irq", irq, 0);
    chk("R10 pps", pps_out, 0);
    rd(5, d); chk("R10 status", d, 0);
    rd(4, d); chk("R10 ctrl", d, 0);

    wr(0, 50);
    rd(0, d); chk("R1 low staged only", d, 0);
    wr(1, 0);
    rd(0, d); chk("R1 commit low", d, 50);

    step(49);
    wr(4, 1);
    step(49);
    rd(5, d); chk("R2 below target", d, 0);
    step(50);
    rd(5, d); chk("R2 equal fires", d, 1);
    chk("R6 masked off", irq, 0);
    wr(6, 3);
    chk("R6 mask on", irq, 1);
    wr(5, 0);
    rd(5, d); chk("R5 write zero keeps", d, 1);
    wr(5, 1);
    rd(5, d); chk("R5 w1c clears", d, 0);
    chk("R6 irq drops", irq, 0);
    step(60); step(60);
    rd(5, d); chk("R3 one shot", d, 0);

    wr(0, 100); wr(1, 0);
    step(60);
    rd(5, d); chk("R3 rearm below", d, 0);
    step(500);
    rd(5, d); chk("R2 R3 jump past fires", d, 1);
    chk("R9 ch0 no pulse", pps_out, 0);
    wr(5, 1);

    wr(4, 0);
    wr(0, 10); wr(1, 0);
    step(600); step(600);
    rd(5, d); chk("R4 disabled", d, 0);

    wr(0, 0); wr(1, 1);
    wr(4, 1);
    step(64'hFFFF_FFFF);
    rd(5, d); chk("R2 below 2^32", d, 0);
    step(64'h1_0000_0000);
    rd(5, d); chk("R2 at 2^32", d, 1);
    rd(1, d); chk("R1 high word", d, 1);
    wr(5, 1);

    wr(4, 0);
    wr(2, 200); wr(3, 0);
    wr(7, 3);
    wr(4, 2);
    step(64'h1_0000_0000);
    rd(5, d); chk("R2 ch1 alarm", d, 2);
    chk("R9 alarm no pulse", pps_out, 0);
    wr(5, 2);

    step(990);
    wr(2, 1000); wr(3, 0);
    wr(4, 6);
    step(990);
    chk("R7 idle low", pps_out, 0);
    expect_pulse(3);
    step(1000);
    chk("R7 pulse starts", pps_out, 1);
    rd(5, d); chk("R8 status", d, 2);
    rd(2, d); chk("R8 advance lo", d, 1000001000);
    rd(3, d); chk("R8 advance hi", d, 0);
    repeat (4) step(1000);
    wr(5, 2);
    step(1000000999);
    rd(5, d); chk("R8 before next second", d, 0);
    wr(7, 1);
    expect_pulse(1);
    step(1000001000);
    rd(5, d); chk("R8 stays armed", d, 2);
    rd(2, d); chk("R8 second advance", d, 2000001000);
    repeat (3) step(1000001000);
    wr(5, 2);

    wr(4, 2);
    step(2000001000);
    rd(5, d); chk("R9 mode off match", d, 2);
    chk("R9 mode off pin", pps_out, 0);
    repeat (3) step(2000001000);

    chk("R7 all pulses seen", exp_w.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule